// File: doc/BRIEF.md
# Integrator Output Soft-Limit Controller

This block watches the digitized output voltage of a closed-loop integrator and keeps it inside a programmable window. Each valid sample is compared with an upper bound and a lower bound. A sample outside the window latches a clamp on that side, and the `hold` output freezes the integrator at its present value. Sticky flags record which side was hit. Software clears a flag by writing a 1 to it.

A clamp ends when a later sample has moved back inside the window by at least the programmed hysteresis margin for that side. By default it also needs an error sign that would move the integrator away from the bound it hit. A control bit can waive the sign test, so that release depends on the voltage alone. The function stays idle until its enable bit is set, and it applies only while the loop runs in closed-loop mode.

Top module: `intlim_guard`

## Requirements
- R1: After reset `hold`, `flag_hi` and `flag_lo` are 0. While `lim_en` is 0, `hold` stays 0 and no sample sets a flag.
- R2: While `cl_mode` is 0, `hold` is 0 in the same cycle. Any clamp in progress is dropped, so `hold` stays 0 when `cl_mode` returns to 1 until a new sample leaves the window.
- R3: In the unclamped state, a valid sample strictly greater than `upper_bound` enters the upper clamp. `hold` and `flag_hi` are 1 from the cycle after that sample's clock edge. A sample equal to the bound does not enter the clamp.
- R4: In the unclamped state, a valid sample strictly less than `lower_bound` enters the lower clamp. `hold` and `flag_lo` are 1 from the next cycle. A sample equal to the bound does not enter the clamp.
- R5: A sample that is above `upper_bound` and also below `lower_bound` (inverted bounds) enters the upper clamp.
- R6: In the upper clamp with `pol_ignore`=0, a valid sample releases the clamp only when two conditions hold on that same sample. The sample must be <= `upper_bound - hyst_hi`, with the difference floored at 0. `drive_up` must be 0, where `drive_up`=1 means the error pushes the integrator upward. `hold` falls in the next cycle.
- R7: In the lower clamp with `pol_ignore`=0, a valid sample releases the clamp only when two conditions hold on that same sample. The sample must be >= `lower_bound + hyst_lo`, with the sum capped at the all-ones code. `drive_up` must be 1.
- R8: With `pol_ignore`=1, release depends only on the hysteresis condition of R6 or R7, and `drive_up` is disregarded.
- R9: A sample that releases a clamp returns the block to the unclamped state only. That same sample is not tested for a new entry.
- R10: A flag stays set until its clear bit is written as 1 (`flag_clr` bit 0 clears `flag_hi`, bit 1 clears `flag_lo`). A new entry on the same cycle as a clear leaves the flag set.
- R11: Cycles with `smp_valid`=0 change neither the clamp state nor the flags. Their data and sign are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lim_en | input | 1 | Limit function enable |
| cl_mode | input | 1 | 1 = closed-loop operation |
| pol_ignore | input | 1 | 1 = release ignores error sign |
| upper_bound | input | DW | Upper voltage bound |
| lower_bound | input | DW | Lower voltage bound |
| hyst_hi | input | DW | Release margin below the upper bound |
| hyst_lo | input | DW | Release margin above the lower bound |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Integrator output sample |
| drive_up | input | 1 | Error sign; 1 = integrator would rise |
| flag_clr | input | 2 | Write-1 clear: bit0 upper flag, bit1 lower flag |
| hold | output | 1 | Freeze request to the integrator |
| flag_hi | output | 1 | Sticky upper-limit flag |
| flag_lo | output | 1 | Sticky lower-limit flag |

## Verification
The bench builds the block with DW=8 rather than the default of 12. Random samples then fall on the bounds, on the exact release thresholds and on both code extremes often enough to exercise them. The narrow width also lets directed cases drive `upper_bound - hyst_hi` below zero and `lower_bound + hyst_lo` past 255, which covers the floor and cap of R6 and R7. Random runs toggle the enable, the loop mode and the sign override between samples, so clamps are also abandoned part-way through.

// File: rtl/intlim_pkg.sv
package intlim_pkg;
  typedef enum logic [1:0] {
    CLP_NONE = 2'd0,
    CLP_HI   = 2'd1,
    CLP_LO   = 2'd2
  } clamp_e;

  localparam int unsigned SIDES   = 2;
  localparam int unsigned SIDE_HI = 0;
  localparam int unsigned SIDE_LO = 1;
endpackage

// File: rtl/intlim_rst_sync.sv
module intlim_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/intlim_thresh.sv
module intlim_thresh #(
  parameter int unsigned DW = 12
) (
  input  logic [DW-1:0] upper_bound,
  input  logic [DW-1:0] lower_bound,
  input  logic [DW-1:0] hyst_hi,
  input  logic [DW-1:0] hyst_lo,
  output logic [DW-1:0] rel_hi,
  output logic [DW-1:0] rel_lo
);
  logic [DW:0] lo_sum;

  // release point below the upper bound, floored at zero
  always_comb begin
    if (upper_bound >= hyst_hi) rel_hi = upper_bound - hyst_hi;
    else                        rel_hi = '0;
  end

  // release point above the lower bound, capped at full scale
  always_comb begin
    lo_sum = {1'b0, lower_bound} + {1'b0, hyst_lo};
    if (lo_sum[DW]) rel_lo = '1;
    else            rel_lo = lo_sum[DW-1:0];
  end
endmodule

// File: rtl/intlim_fsm.sv
module intlim_fsm
  import intlim_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic [DW-1:0] upper_bound,
  input  logic [DW-1:0] lower_bound,
  input  logic [DW-1:0] rel_hi,
  input  logic [DW-1:0] rel_lo,
  input  logic          drive_up,
  input  logic          pol_ignore,
  output clamp_e        st_q,
  output logic          enter_hi,
  output logic          enter_lo
);
  clamp_e st_d;
  logic   st_upd;
  logic   ok_hi;
  logic   ok_lo;

  assign ok_hi  = (smp_data <= rel_hi) && (pol_ignore || !drive_up);
  assign ok_lo  = (smp_data >= rel_lo) && (pol_ignore || drive_up);
  assign st_upd = !active || smp_valid;

  always_comb begin
    st_d     = st_q;
    enter_hi = 1'b0;
    enter_lo = 1'b0;
    if (!active) begin
      st_d = CLP_NONE;
    end else if (smp_valid) begin
      unique case (st_q)
        CLP_NONE: begin
          if (smp_data > upper_bound) begin
            st_d     = CLP_HI;
            enter_hi = 1'b1;
          end else if (smp_data < lower_bound) begin
            st_d     = CLP_LO;
            enter_lo = 1'b1;
          end
        end
        CLP_HI:  if (ok_hi) st_d = CLP_NONE;
        CLP_LO:  if (ok_lo) st_d = CLP_NONE;
        default: st_d = CLP_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= CLP_NONE;
    else if (st_upd) st_q <= st_d;
  end
endmodule

// File: rtl/intlim_flags.sv
module intlim_flags
  import intlim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SIDES-1:0] set_in,
  input  logic [SIDES-1:0] clr_in,
  output logic [SIDES-1:0] flag_q
);
  for (genvar i = 0; i < SIDES; i++) begin : g_side
    logic flag_d;
    logic flag_en;

    assign flag_en = set_in[i] || clr_in[i];

    always_comb begin
      if (set_in[i]) flag_d = 1'b1;
      else           flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q[i] <= 1'b0;
      else if (flag_en) flag_q[i] <= flag_d;
    end
  end
endmodule

// File: rtl/intlim_guard.sv
module intlim_guard
  import intlim_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lim_en,
  input  logic          cl_mode,
  input  logic          pol_ignore,
  input  logic [DW-1:0] upper_bound,
  input  logic [DW-1:0] lower_bound,
  input  logic [DW-1:0] hyst_hi,
  input  logic [DW-1:0] hyst_lo,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          drive_up,
  input  logic [1:0]    flag_clr,
  output logic          hold,
  output logic          flag_hi,
  output logic          flag_lo
);
  logic             rst_n_i;
  logic             active;
  logic [DW-1:0]    rel_hi;
  logic [DW-1:0]    rel_lo;
  clamp_e           st_q;
  logic             enter_hi;
  logic             enter_lo;
  logic [SIDES-1:0] flag_set;
  logic [SIDES-1:0] flag_q;

  assign active = lim_en && cl_mode;

  intlim_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  intlim_thresh #(.DW(DW)) u_thr (
    .upper_bound (upper_bound),
    .lower_bound (lower_bound),
    .hyst_hi     (hyst_hi),
    .hyst_lo     (hyst_lo),
    .rel_hi      (rel_hi),
    .rel_lo      (rel_lo)
  );

  intlim_fsm #(.DW(DW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .active      (active),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .upper_bound (upper_bound),
    .lower_bound (lower_bound),
    .rel_hi      (rel_hi),
    .rel_lo      (rel_lo),
    .drive_up    (drive_up),
    .pol_ignore  (pol_ignore),
    .st_q        (st_q),
    .enter_hi    (enter_hi),
    .enter_lo    (enter_lo)
  );

  assign flag_set[SIDE_HI] = enter_hi;
  assign flag_set[SIDE_LO] = enter_lo;

  intlim_flags u_flg (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .set_in (flag_set),
    .clr_in (flag_clr),
    .flag_q (flag_q)
  );

  assign hold    = active && (st_q != CLP_NONE);
  assign flag_hi = flag_q[SIDE_HI];
  assign flag_lo = flag_q[SIDE_LO];
endmodule

// File: rtl/intlim_guard_chk.sv
module intlim_guard_chk #(
  parameter int unsigned DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lim_en,
  input logic          cl_mode,
  input logic          pol_ignore,
  input logic [DW-1:0] upper_bound,
  input logic [DW-1:0] lower_bound,
  input logic          smp_valid,
  input logic [DW-1:0] smp_data,
  input logic          drive_up,
  input logic [1:0]    flag_clr,
  input logic          hold,
  input logic          flag_hi,
  input logic          flag_lo,
  input logic          clamp_hi
);
  logic act;
  assign act = lim_en && cl_mode;

  a_r1_disabled_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lim_en |-> !hold);

  a_r2_open_loop_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cl_mode |-> !hold);

  a_r3_enter_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !hold && smp_valid && (smp_data > upper_bound))
      |=> (flag_hi && (hold || !(lim_en && cl_mode))));

  a_r4_lo_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_lo) |-> $past(smp_valid && (smp_data < lower_bound)));

  a_r6_wrong_sign_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (act && clamp_hi && smp_valid && !pol_ignore && drive_up)
      |=> (hold || !(lim_en && cl_mode)));

  a_r10_flag_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_hi) |-> $past(flag_clr[0]));

  a_r10_flag_lo_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_lo) |-> $past(flag_clr[1]));

  a_r11_hold_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(smp_valid));
endmodule

bind intlim_guard intlim_guard_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lim_en      (lim_en),
  .cl_mode     (cl_mode),
  .pol_ignore  (pol_ignore),
  .upper_bound (upper_bound),
  .lower_bound (lower_bound),
  .smp_valid   (smp_valid),
  .smp_data    (smp_data),
  .drive_up    (drive_up),
  .flag_clr    (flag_clr),
  .hold        (hold),
  .flag_hi     (flag_hi),
  .flag_lo     (flag_lo),
  .clamp_hi    (st_q == intlim_pkg::CLP_HI)
);

// File: tb/intlim_guard_bench.sv
`timescale 1ns/1ps
module intlim_guard_bench;
  localparam int unsigned DW   = 8;
  localparam int          MAXV = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lim_en, cl_mode, pol_ignore;
  logic          smp_valid, drive_up;
  logic [DW-1:0] smp_data;
  logic [1:0]    flag_clr;
  logic          hold, flag_hi, flag_lo;
  int            ub, lb, hh, hl;
  int            n_chk = 0;
  int            n_bad = 0;
  int            m_st = 0;
  bit            m_fh = 0;
  bit            m_fl = 0;

  always #4 clk = ~clk;

  intlim_guard #(.DW(DW)) u_intlim_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .lim_en      (lim_en),
    .cl_mode     (cl_mode),
    .pol_ignore  (pol_ignore),
    .upper_bound (ub[DW-1:0]),
    .lower_bound (lb[DW-1:0]),
    .hyst_hi     (hh[DW-1:0]),
    .hyst_lo     (hl[DW-1:0]),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .drive_up    (drive_up),
    .flag_clr    (flag_clr),
    .hold        (hold),
    .flag_hi     (flag_hi),
    .flag_lo     (flag_lo)
  );

  task automatic check(string tag, logic got, bit exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int rel_upper();
    return (ub >= hh) ? ub - hh : 0;
  endfunction

  function automatic int rel_lower();
    return (lb + hl > MAXV) ? MAXV : lb + hl;
  endfunction

  task automatic step(string tag, bit v, int d, bit du, bit [1:0] clr);
    int  nst;
    bit  act;
    bit  eh;
    bit  el;
    @(negedge clk);
    smp_valid = v;
    smp_data  = d[DW-1:0];
    drive_up  = du;
    flag_clr  = clr;
    act = lim_en && cl_mode;
    nst = m_st;
    eh  = 0;
    el  = 0;
    if (!act) nst = 0;
    else if (v) begin
      if (m_st == 0) begin
        if (d > ub) begin nst = 1; eh = 1; end
        else if (d < lb) begin nst = 2; el = 1; end
      end else if (m_st == 1) begin
        if (d <= rel_upper() && (pol_ignore || !du)) nst = 0;
      end else begin
        if (d >= rel_lower() && (pol_ignore || du)) nst = 0;
      end
    end
    @(posedge clk);
    #1;
    m_st = nst;
    if (eh) m_fh = 1; else if (clr[0]) m_fh = 0;
    if (el) m_fl = 1; else if (clr[1]) m_fl = 0;
    check({tag, " hold"}, hold, (m_st != 0) && lim_en && cl_mode);
    check({tag, " flag_hi"}, flag_hi, m_fh);
    check({tag, " flag_lo"}, flag_lo, m_fl);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lim_en = 0; cl_mode = 1; pol_ignore = 0;
    smp_valid = 0; smp_data = '0; drive_up = 0; flag_clr = 2'b00;
    ub = 200; lb = 50; hh = 10; hl = 10;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset hold", hold, 0);
    check("R1 reset flag_hi", flag_hi, 0);
    check("R1 reset flag_lo", flag_lo, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    step("R1 disabled", 1, 250, 0, 0);
    step("R1 disabled low", 1, 10, 1, 0);
    lim_en = 1;
    step("R3 equal bound", 1, 200, 0, 0);
    step("R3 enter upper", 1, 201, 0, 0);
    step("R6 wrong sign", 1, 185, 1, 0);
    step("R6 inside hysteresis", 1, 195, 0, 0);
    step("R11 invalid ignored", 0, 100, 0, 0);
    step("R6 release", 1, 190, 0, 0);
    step("R11 invalid no entry", 0, 255, 0, 0);
    step("R4 equal bound", 1, 50, 0, 0);
    step("R4 enter lower", 1, 49, 0, 0);
    step("R7 wrong sign", 1, 70, 0, 0);
    step("R7 inside hysteresis", 1, 59, 1, 0);
    step("R7 release", 1, 60, 1, 0);
    step("R10 clear hi", 0, 0, 0, 2'b01);
    step("R10 clear lo", 0, 0, 0, 2'b10);
    step("R10 set beats clear", 1, 220, 0, 2'b01);
    pol_ignore = 1;
    step("R8 ignore sign", 1, 150, 1, 0);
    step("R8 enter lower", 1, 20, 0, 0);
    step("R8 lower release", 1, 61, 0, 0);
    pol_ignore = 0;
    step("R2 enter", 1, 230, 0, 0);
    cl_mode = 0;
    step("R2 open loop", 0, 0, 0, 0);
    step("R2 open loop sample", 1, 240, 0, 0);
    cl_mode = 1;
    step("R2 back closed", 0, 0, 0, 0);
    ub = 5; hh = 20;
    step("R6 floor enter", 1, 6, 0, 0);
    step("R6 floor hold", 1, 1, 0, 0);
    step("R6 floor release", 1, 0, 0, 0);
    ub = 255; lb = 250; hl = 20;
    step("R7 cap enter", 1, 249, 1, 0);
    step("R7 cap hold", 1, 254, 1, 0);
    step("R7 cap release", 1, 255, 1, 0);
    ub = 100; lb = 150;
    step("R5 inverted bounds", 1, 120, 0, 2'b11);
    step("R9 release only", 1, 10, 0, 0);
    step("R9 next sample enters", 1, 10, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 40) == 0) lim_en = ($urandom_range(0, 5) != 0);
      if ($urandom_range(0, 40) == 0) cl_mode = ($urandom_range(0, 5) != 0);
      if ($urandom_range(0, 30) == 0) pol_ignore = $urandom_range(0, 1);
      if ($urandom_range(0, 60) == 0) begin
        ub = $urandom_range(100, MAXV);
        lb = $urandom_range(0, 150);
        hh = $urandom_range(0, 40);
        hl = $urandom_range(0, 40);
      end
      step("RND", $urandom_range(0, 3) != 0, $urandom_range(0, MAXV),
           $urandom_range(0, 1), ($urandom_range(0, 15) == 0) ? 2'($urandom_range(1, 3)) : 2'b00);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5a_7e03));
  end
endmodule